// File: doc/BRIEF.md
# Variable-Allocation Sum-of-Products Array

This block is the programmable AND-OR core that sits in front of ten output macrocells. Twelve dedicated inputs and ten macrocell feedbacks are offered to every product term in both true and inverted form. Each product term is the AND of whichever literals its connection bits keep. Each output's sum term is the OR of a private group of product terms. The groups differ in size: outputs are taken two at a time, and successive pairs get two more terms than the pair before them.

Besides the sum terms, the array forms one output-enable term per output and two terms shared by all registers: an asynchronous-reset term and a synchronous-preset term. The array itself is purely combinational. Its connection bits live in a configuration store that is written one row at a time through a word-wide port, before the logic is put to use. The macrocell registers, polarity selection and pin drivers are outside this block.

Top module: `vsop_array`

## Requirements
- R1: While and after reset with no configuration written, every connection bit is 1 (intact). As a result, sum_out, oe_out, areset_out and spreset_out are all 0.
- R2: A row has 44 bits. For signal index k, bit 2k connects the true literal and bit 2k+1 connects the inverted literal. Indices k = 0..11 are dat_in[k] and k = 12..21 are fb_in[k-12]. A set bit keeps the literal. A product term is the AND of its kept literals.
- R3: Output o owns 8 + 2*(o/2) product terms, using integer division. Its rows follow directly after those of output o-1, starting at row 0, so the sum rows are 0..119 (output 1 starts at row 8, output 5 at row 48, output 9 ends at row 119). sum_out[o] is the OR of its own rows only.
- R4: Row 120+o is the output-enable term of output o and drives oe_out[o].
- R5: Row 130 drives areset_out and row 131 drives spreset_out.
- R6: A row with all bits set evaluates to 0, because it ANDs x with NOT x. A row with all bits clear evaluates to 1.
- R7: A write with cfg_we high at a rising clk edge replaces row cfg_row with cfg_data. The outputs reflect the new row from that edge onward, and not before it. Changes on dat_in and fb_in reach the outputs in the same cycle.
- R8: A write to a row number of 132 or above changes no connection bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset; sets every connection bit |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 8 | Row number to write |
| cfg_data | input | 44 | Connection bits for the row |
| dat_in | input | 12 | Dedicated inputs |
| fb_in | input | 10 | Macrocell feedbacks |
| sum_out | output | 10 | Sum term per output |
| oe_out | output | 10 | Output-enable term per output |
| areset_out | output | 1 | Shared asynchronous-reset term |
| spreset_out | output | 1 | Shared synchronous-preset term |

## Verification
A changed row is visible one rising edge after its write strobe. The bench therefore drives each write at a falling edge and compares the outputs half a period after the next rising edge. For the latency case, it also samples just after the strobe is driven to confirm that the old row still governs. Input changes reach the outputs with zero cycles of delay, so input patterns are applied at a falling edge and compared 1 ns later in the same low phase. A row number of 132 or above is followed by a full output comparison against a model that dropped the write.

// File: rtl/vsop_pkg.sv
package vsop_pkg;

   // number of product terms owned by output o (pairs grow by step)
   function automatic int terms_of(input int o, input int base, input int step);
      return base + step * (o / 2);
   endfunction

   // first row owned by output o (rows of outputs 0..o-1 precede it)
   function automatic int first_row(input int o, input int base, input int step);
      int acc;
      acc = 0;
      for (int j = 0; j < o; j++) acc += terms_of(j, base, step);
      return acc;
   endfunction

   typedef enum logic [1:0] {
      ROW_SUM   = 2'd0,
      ROW_OE    = 2'd1,
      ROW_ARST  = 2'd2,
      ROW_SPRE  = 2'd3
   } row_kind_e;

endpackage

// File: rtl/product_term.sv
module product_term #(
   parameter int N_SIG = 22
) (
   input  logic [N_SIG-1:0]   sig,
   input  logic [2*N_SIG-1:0] conn,
   output logic               term
);
   logic [2*N_SIG-1:0] lit;

   for (genvar k = 0; k < N_SIG; k++) begin : g_lit
      assign lit[2*k]   = sig[k];
      assign lit[2*k+1] = ~sig[k];
   end

   // a removed connection forces its literal position to 1
   assign term = &(lit | ~conn);
endmodule

// File: rtl/pterm_plane.sv
module pterm_plane #(
   parameter int N_SIG  = 22,
   parameter int N_ROWS = 132
) (
   input  logic [N_SIG-1:0]                    sig,
   input  logic [N_ROWS-1:0][2*N_SIG-1:0]      fuse,
   output logic [N_ROWS-1:0]                   pt
);
   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      product_term #(.N_SIG(N_SIG)) u_term (
         .sig  (sig),
         .conn (fuse[r]),
         .term (pt[r])
      );
   end
endmodule

// File: rtl/sum_plane.sv
module sum_plane #(
   parameter int N_OUT      = 10,
   parameter int BASE_TERMS = 8,
   parameter int STEP_TERMS = 2,
   parameter int N_PT       = 120
) (
   input  logic [N_PT-1:0]  pt,
   output logic [N_OUT-1:0] sum
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      localparam int OFF = vsop_pkg::first_row(o, BASE_TERMS, STEP_TERMS);
      localparam int CNT = vsop_pkg::terms_of(o, BASE_TERMS, STEP_TERMS);
      if (OFF + CNT > N_PT) begin : g_bad
         $error("sum_plane: output %0d exceeds product-term range", o);
      end else begin : g_or
         assign sum[o] = |pt[OFF +: CNT];
      end
   end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
   parameter int ROW_W  = 44,
   parameter int N_ROWS = 132,
   parameter int ROW_AW = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ROW_AW-1:0]             row,
   input  logic [ROW_W-1:0]              data,
   output logic [N_ROWS-1:0][ROW_W-1:0]  fuse_q
);
   logic in_range;
   assign in_range = ({1'b0, row} < (ROW_AW+1)'(N_ROWS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fuse_q <= '1;
      end else if (we && in_range) begin
         fuse_q[row] <= data;
      end
   end
endmodule

// File: rtl/vsop_array.sv
module vsop_array #(
   parameter int N_IN       = 12,
   parameter int N_OUT      = 10,
   parameter int BASE_TERMS = 8,
   parameter int STEP_TERMS = 2,
   localparam int N_SIG     = N_IN + N_OUT,
   localparam int ROW_W     = 2 * N_SIG,
   localparam int N_SUM     = vsop_pkg::first_row(N_OUT, BASE_TERMS, STEP_TERMS),
   localparam int OE_BASE   = N_SUM,
   localparam int AR_ROW    = N_SUM + N_OUT,
   localparam int SP_ROW    = AR_ROW + 1,
   localparam int N_ROWS    = SP_ROW + 1,
   localparam int ROW_AW    = $clog2(N_ROWS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ROW_AW-1:0] cfg_row,
   input  logic [ROW_W-1:0]  cfg_data,
   input  logic [N_IN-1:0]   dat_in,
   input  logic [N_OUT-1:0]  fb_in,
   output logic [N_OUT-1:0]  sum_out,
   output logic [N_OUT-1:0]  oe_out,
   output logic              areset_out,
   output logic              spreset_out
);
   if (N_OUT < 2 || (N_OUT % 2) != 0) begin : g_chk_out
      $error("vsop_array: N_OUT must be a positive even count");
   end
   if (N_IN < 1) begin : g_chk_in
      $error("vsop_array: N_IN must be at least 1");
   end
   if (BASE_TERMS < 1 || STEP_TERMS < 0) begin : g_chk_terms
      $error("vsop_array: bad product-term allocation");
   end

   logic [N_ROWS-1:0][ROW_W-1:0] fuse_q;
   logic [N_ROWS-1:0]            pt;
   logic [N_SIG-1:0]             sig;

   // signal index: dedicated inputs low, feedbacks above
   assign sig = {fb_in, dat_in};

   cfg_store #(.ROW_W(ROW_W), .N_ROWS(N_ROWS), .ROW_AW(ROW_AW)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .row    (cfg_row),
      .data   (cfg_data),
      .fuse_q (fuse_q)
   );

   pterm_plane #(.N_SIG(N_SIG), .N_ROWS(N_ROWS)) u_and (
      .sig  (sig),
      .fuse (fuse_q),
      .pt   (pt)
   );

   sum_plane #(
      .N_OUT(N_OUT), .BASE_TERMS(BASE_TERMS), .STEP_TERMS(STEP_TERMS), .N_PT(N_SUM)
   ) u_or (
      .pt  (pt[N_SUM-1:0]),
      .sum (sum_out)
   );

   assign oe_out      = pt[OE_BASE +: N_OUT];
   assign areset_out  = pt[AR_ROW];
   assign spreset_out = pt[SP_ROW];
endmodule

// File: rtl/vsop_array_chk.sv
module vsop_array_chk #(
   parameter int N_OUT   = 10,
   parameter int ROW_W   = 44,
   parameter int N_ROWS  = 132,
   parameter int ROW_AW  = 8,
   parameter int OE_BASE = 120,
   parameter int AR_ROW  = 130,
   parameter int SP_ROW  = 131
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_we,
   input logic [ROW_AW-1:0]             cfg_row,
   input logic [ROW_W-1:0]              cfg_data,
   input logic [N_ROWS-1:0][ROW_W-1:0]  fuse_q,
   input logic [N_OUT-1:0]              oe_out,
   input logic                          areset_out,
   input logic                          spreset_out
);
   logic in_range;
   assign in_range = ({1'b0, cfg_row} < (ROW_AW+1)'(N_ROWS));

   a_r8_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !in_range) |=> $stable(fuse_q));

   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && in_range) |=> (fuse_q[$past(cfg_row)] == $past(cfg_data)));

   a_r6_intact_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (&fuse_q[AR_ROW]) |-> !areset_out);

   a_r6_empty_is_one: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_q[SP_ROW] == '0) |-> spreset_out);

   a_r4_oe_intact_off: assert property (@(posedge clk) disable iff (!rst_n)
      (&fuse_q[OE_BASE]) |-> !oe_out[0]);
endmodule

bind vsop_array vsop_array_chk #(
   .N_OUT(N_OUT), .ROW_W(ROW_W), .N_ROWS(N_ROWS), .ROW_AW(ROW_AW),
   .OE_BASE(OE_BASE), .AR_ROW(AR_ROW), .SP_ROW(SP_ROW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
   .fuse_q(fuse_q), .oe_out(oe_out), .areset_out(areset_out), .spreset_out(spreset_out)
);

// File: tb/vsop_array_bench.sv
module vsop_array_bench;
   localparam int NI = 12;
   localparam int NO = 10;
   localparam int RW = 44;
   localparam int NR = 132;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_row = '0;
   logic [RW-1:0] cfg_data = '0;
   logic [NI-1:0] dat_in = '0;
   logic [NO-1:0] fb_in = '0;
   logic [NO-1:0] sum_out, oe_out;
   logic          areset_out, spreset_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [RW-1:0] m [NR];

   always #4 clk = ~clk;

   vsop_array u_vsop_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
      .dat_in(dat_in), .fb_in(fb_in), .sum_out(sum_out), .oe_out(oe_out),
      .areset_out(areset_out), .spreset_out(spreset_out)
   );

   // R3 allocation, computed independently
   function automatic int row0(input int o);
      int s = 0;
      for (int j = 0; j < o; j++) s += 8 + 2 * (j / 2);
      return s;
   endfunction

   function automatic logic eval_row(input int r);
      for (int k = 0; k < 22; k++) begin
         logic s;
         s = (k < NI) ? dat_in[k] : fb_in[k-NI];
         if (m[r][2*k] && !s) return 1'b0;
         if (m[r][2*k+1] && s) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic chk1(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      logic [NO-1:0] es, eo;
      for (int o = 0; o < NO; o++) begin
         es[o] = 1'b0;
         for (int r = row0(o); r < row0(o) + 8 + 2 * (o / 2); r++) es[o] |= eval_row(r);
         eo[o] = eval_row(120 + o);
      end
      chk1({req, " sum"}, 32'(sum_out), 32'(es));
      chk1({req, " oe"},  32'(oe_out),  32'(eo));
      chk1({req, " ar"},  32'(areset_out),  32'(eval_row(130)));
      chk1({req, " sp"},  32'(spreset_out), 32'(eval_row(131)));
   endtask

   task automatic write_row(input int r, input logic [RW-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 8'(r); cfg_data = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (r < NR) m[r] = v;
      #1;
   endtask

   function automatic logic [RW-1:0] sparse();
      logic [RW-1:0] v = '0;
      int n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) v[$urandom_range(0, RW-1)] = 1'b1;
      return v;
   endfunction

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int r = 0; r < NR; r++) m[r] = '1;
      repeat (3) @(negedge clk);
      #1;
      chk1("R1 sum in reset", 32'(sum_out), 0);
      rst_n = 1'b1;
      dat_in = 12'hA5C; fb_in = 10'h2F1;
      #1;
      check_all("R1");
      chk1("R1 all zero", 32'({sum_out, oe_out, areset_out, spreset_out}), 0);

      // R6 empty row is 1, intact row is 0
      write_row(130, '0);
      chk1("R6 empty ar", 32'(areset_out), 1);
      write_row(130, '1);
      chk1("R6 intact ar", 32'(areset_out), 0);

      // R2 encoding: row 0 = dat_in[0] AND NOT fb_in[0]
      write_row(0, RW'(1) | (RW'(1) << (2*12+1)));
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         dat_in[0] = c[0]; fb_in[0] = c[1];
         #1;
         chk1("R2 literal", 32'(sum_out[0]), 32'(c[0] & ~c[1]));
      end
      write_row(0, '1);

      // R3 boundaries: row 8 belongs to output 1, row 119 to output 9
      write_row(8, '0);
      chk1("R3 first row of out1", 32'(sum_out), 32'h002);
      write_row(8, '1);
      write_row(119, '0);
      chk1("R3 last row of out9", 32'(sum_out), 32'h200);
      write_row(119, '1);

      // R4 output enable of output 3
      write_row(123, '0);
      chk1("R4 oe row", 32'(oe_out), 32'h008);
      write_row(123, '1);

      // R5 preset row
      write_row(131, '0);
      chk1("R5 sp row", 32'({areset_out, spreset_out}), 32'h1);
      write_row(131, '1);

      // R7 latency: row 48 is the first row of output 5
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 8'd48; cfg_data = '0;
      #1;
      chk1("R7 before edge", 32'(sum_out[5]), 0);
      @(negedge clk);
      cfg_we = 1'b0; m[48] = '0;
      #1;
      chk1("R7 after edge", 32'(sum_out[5]), 1);
      write_row(48, '1);

      // R8 out-of-range rows
      write_row(200, '0);
      check_all("R8");
      write_row(132, '0);
      check_all("R8");

      // random mix
      for (int it = 0; it < 300; it++) begin
         int r = $urandom_range(0, NR-1);
         write_row(r, ($urandom_range(0, 15) == 0) ? RW'(0) : sparse());
         for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            dat_in = NI'($urandom); fb_in = NO'($urandom);
            #1;
            check_all("R3");
         end
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule